// File: doc/BRIEF.md
# Two-Wire EEPROM Transaction Master

This block runs whole transactions against a serial EEPROM on a two-wire bus (clock plus open-drain data). A host sets a command code, a byte address, write data and a clock divider value, then pulses `start` for one cycle. The engine walks a fixed list of steps for that command: START condition, control byte, address byte, data byte, repeated START, acknowledge slots and STOP. It then pulses `done`, reports a one-bit status and, for reads, the byte returned by the memory.

A failed status means that some byte was not acknowledged. This normally happens while the memory is still committing an earlier write, which can take a few milliseconds. The host is expected to issue the command again later, because the engine does not retry by itself. The clock line is driven push-pull. The data line can only pull low: driving a 1 releases it to the pull-up, and that is how the engine reads acknowledges and data bits.

Top module: `twi_eeprom_master`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `scl_o`=1, `sda_o`=1, `busy`=0, `done`=0, `ok`=0 and `rd_data`=0.
- R2: A `start` pulse while idle latches `cmd`, `addr`, `wdata` and `clk_div`, and `busy` is high from the next cycle. A `start` pulse while busy is ignored, and so are changes to those inputs. Command codes: 00 byte write, 01 current read, 10 random read, 11 behaves as 01.
- R3: A byte write sends START, the control byte, the address, the data byte and STOP. The control byte is 4'b1010, then the 3-bit `DEV_SEL`, then a read/write flag in bit 0 (0 = write, 1 = read). `ok`=1 when every byte is acknowledged.
- R4: A current read sends START and the control byte with the read flag. It then clocks in 8 data bits, gives a master not-acknowledge (SDA released) and sends STOP. The byte appears on `rd_data` with `ok`=1.
- R5: A random read sends START, the write control byte, the address, a repeated START, the read control byte, one data byte with not-acknowledge, and STOP.
- R6: When a byte sent by the master is not acknowledged (SDA sampled 1 in its ninth bit slot), the sequence goes straight to STOP and `ok`=0. `rd_data` keeps its previous value.
- R7: SDA changes while SCL is high only to form START or STOP, and never while idle. Both lines rest at 1 when idle. `sda_o`=1 releases the line. Bytes are sent MSB first.
- R8: Each bit slot has 4 phases of `clk_div`+1 cycles each. SCL is high in phases 1 and 2. SDA is set in phase 0 and sampled at the end of phase 2.
- R9: `busy` stays high for exactly slots×4×(`clk_div`+1) cycles, where a transaction has 29 slots for a write, 20 for a current read and 39 for a random read. An abort shortens this to 11 slots after the control byte or 20 after the address. `done` is a single-cycle pulse on the cycle `busy` falls. `ok` and `rd_data` hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| cmd | input | 2 | Command code |
| addr | input | 8 | Memory byte address |
| wdata | input | 8 | Byte to write |
| clk_div | input | DIV_W | Phase length minus one, in clock cycles |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Status of last transaction: 1 success, 0 failure |
| rd_data | output | 8 | Last byte read |
| scl_o | output | 1 | Serial clock, push-pull |
| sda_o | output | 1 | Serial data drive, 0 pulls low, 1 releases |
| sda_i | input | 1 | Sampled level of the data line |

## Verification
A behavioural memory model on the bus decodes START, STOP and bytes. The bench runs writes, current reads and random reads, each followed by a read-back, so the address pointer carried between commands is exercised as well as the data. Transactions are repeated with a not-acknowledge forced at the control, address and data byte. These runs separate an early abort from a late one by the bus log and by the exact length of `busy`. Divider values of 0 to 3 and a `start` pulse fired mid-transaction with different inputs show that timing scales with the divider and that the latched inputs cannot be disturbed.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] CTRL_TAG = 4'b1010;

    typedef enum logic [1:0] {
        CMD_WRITE     = 2'b00,
        CMD_READ_CUR  = 2'b01,
        CMD_READ_RAND = 2'b10,
        CMD_READ_ALT  = 2'b11
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_CTRL_WR, ST_ADDR, ST_WDATA,
        ST_RESTART, ST_CTRL_RD, ST_RDATA, ST_STOP
    } step_e;

    typedef enum logic [1:0] {SLOT_IDLE, SLOT_START, SLOT_STOP, SLOT_BIT} slot_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    // Ordered step list for each command
    function automatic step_e next_step(cmd_e c, step_e s);
        case (s)
            ST_START:   return (c == CMD_WRITE || c == CMD_READ_RAND) ? ST_CTRL_WR : ST_CTRL_RD;
            ST_CTRL_WR: return ST_ADDR;
            ST_ADDR:    return (c == CMD_WRITE) ? ST_WDATA : ST_RESTART;
            ST_WDATA:   return ST_STOP;
            ST_RESTART: return ST_CTRL_RD;
            ST_CTRL_RD: return ST_RDATA;
            ST_RDATA:   return ST_STOP;
            default:    return ST_IDLE;
        endcase
    endfunction

    function automatic logic is_byte(step_e s);
        return (s == ST_CTRL_WR) || (s == ST_ADDR) || (s == ST_WDATA) ||
               (s == ST_CTRL_RD) || (s == ST_RDATA);
    endfunction

    function automatic logic is_tx_byte(step_e s);
        return is_byte(s) && (s != ST_RDATA);
    endfunction

    function automatic slot_e slot_of(step_e s);
        if (s == ST_START || s == ST_RESTART) return SLOT_START;
        if (s == ST_STOP) return SLOT_STOP;
        if (is_byte(s)) return SLOT_BIT;
        return SLOT_IDLE;
    endfunction

    // Line levels for each phase of a slot
    function automatic lines_t slot_lines(slot_e k, logic [1:0] ph, logic b);
        lines_t l;
        l.scl = 1'b1;
        l.sda = 1'b1;
        case (k)
            SLOT_BIT: begin
                l.scl = (ph == 2'd1) || (ph == 2'd2);
                l.sda = b;
            end
            SLOT_START: begin
                l.scl = (ph == 2'd1) || (ph == 2'd2);
                l.sda = (ph < 2'd2);
            end
            SLOT_STOP: begin
                l.scl = (ph != 2'd0);
                l.sda = (ph >= 2'd2);
            end
            default: ;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/twi_phase_timer.sv
module twi_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_len,
    output logic [1:0]       phase,
    output logic             phase_end,
    output logic             slot_end
);
    logic [DIV_W-1:0] cnt_q;
    logic [1:0]       ph_q;

    assign phase     = ph_q;
    assign phase_end = run && (cnt_q == div_len);
    assign slot_end  = phase_end && (ph_q == 2'd3);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            ph_q  <= '0;
        end else if (phase_end) begin
            cnt_q <= '0;
            ph_q  <= ph_q + 2'd1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/twi_byte_shifter.sv
module twi_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_out,
    input  logic         shift_in,
    input  logic         in_bit,
    output logic [W-1:0] q
);
    logic [W-1:0] sh_q;
    assign q = sh_q;

    always_ff @(posedge clk) begin
        if (rst)            sh_q <= '0;
        else if (load)      sh_q <= load_val;
        else if (shift_out) sh_q <= {sh_q[W-2:0], 1'b0};
        else if (shift_in)  sh_q <= {sh_q[W-2:0], in_bit};
    end
endmodule

// File: rtl/twi_eeprom_master.sv
module twi_eeprom_master
    import twi_eeprom_pkg::*;
#(
    parameter int         DIV_W   = 8,
    parameter logic [2:0] DEV_SEL = 3'b000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        cmd,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              busy,
    output logic              done,
    output logic              ok,
    output logic [BYTE_W-1:0] rd_data,
    output logic              scl_o,
    output logic              sda_o,
    input  logic              sda_i
);
    localparam int BIT_IDX_W = $clog2(BYTE_W + 1);
    localparam logic [BIT_IDX_W-1:0] ACK_IDX = BIT_IDX_W'(BYTE_W);

    step_e               step_q;
    cmd_e                cmd_q;
    logic [BIT_IDX_W-1:0] bitn_q;
    logic [BYTE_W-1:0]   addr_q, wdat_q, rd_q, sh_q, sh_val;
    logic [DIV_W-1:0]    div_q;
    logic                busy_q, done_q, ok_q, fail_q, nack_q;
    lines_t              lines_q, lines_d;

    logic [1:0] phase;
    logic       ph_end, slot_end;
    logic       last_bit, advance, ack_fail, sample_en, tx_bit;
    logic       sh_load, sh_shift, sh_sample;
    step_e      nxt;

    twi_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst(rst), .run(busy_q), .div_len(div_q),
        .phase(phase), .phase_end(ph_end), .slot_end(slot_end)
    );

    twi_byte_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .load_val(sh_val),
        .shift_out(sh_shift), .shift_in(sh_sample), .in_bit(sda_i), .q(sh_q)
    );

    always_comb begin
        nxt       = next_step(cmd_q, step_q);
        last_bit  = (bitn_q == ACK_IDX);
        ack_fail  = is_tx_byte(step_q) && nack_q;
        advance   = busy_q && slot_end && (!is_byte(step_q) || last_bit);
        sample_en = busy_q && ph_end && (phase == 2'd2);
        tx_bit    = (is_tx_byte(step_q) && !last_bit) ? sh_q[BYTE_W-1] : 1'b1;
        sh_load   = advance && !ack_fail;
        sh_shift  = busy_q && slot_end && is_tx_byte(step_q) && !last_bit;
        sh_sample = sample_en && (step_q == ST_RDATA) && !last_bit;
        case (nxt)
            ST_CTRL_WR: sh_val = {CTRL_TAG, DEV_SEL, 1'b0};
            ST_CTRL_RD: sh_val = {CTRL_TAG, DEV_SEL, 1'b1};
            ST_ADDR:    sh_val = addr_q;
            ST_WDATA:   sh_val = wdat_q;
            default:    sh_val = '0;
        endcase
        lines_d = slot_lines(slot_of(step_q), phase, tx_bit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= ST_IDLE;
            cmd_q   <= CMD_WRITE;
            bitn_q  <= '0;
            addr_q  <= '0;
            wdat_q  <= '0;
            div_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
            fail_q  <= 1'b0;
            nack_q  <= 1'b0;
            rd_q    <= '0;
            lines_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            done_q  <= 1'b0;
            lines_q <= lines_d;
            if (sample_en && last_bit) nack_q <= sda_i;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    cmd_q  <= cmd_e'(cmd);
                    addr_q <= addr;
                    wdat_q <= wdata;
                    div_q  <= clk_div;
                    step_q <= ST_START;
                    bitn_q <= '0;
                    fail_q <= 1'b0;
                end
            end else if (slot_end) begin
                if (is_byte(step_q) && !last_bit) begin
                    bitn_q <= bitn_q + 1'b1;
                end else begin
                    bitn_q <= '0;
                    if (ack_fail) begin
                        fail_q <= 1'b1;
                        step_q <= ST_STOP;
                    end else if (step_q == ST_STOP) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        ok_q   <= !fail_q;
                        step_q <= ST_IDLE;
                    end else begin
                        if (step_q == ST_RDATA) rd_q <= sh_q;
                        step_q <= nxt;
                    end
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign ok      = ok_q;
    assign rd_data = rd_q;
    assign scl_o   = lines_q.scl;
    assign sda_o   = lines_q.sda;
endmodule

// File: rtl/twi_eeprom_master_chk.sv
module twi_eeprom_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       scl_o,
    input logic       sda_o,
    input logic [1:0] cmd_q
);
    AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (scl_o && sda_o)); // R7

    AST_SDA_EDGE_UNDER_SCL_BUSY: assert property (@(posedge clk) disable iff (rst)
        (scl_o && $past(scl_o) && (sda_o != $past(sda_o))) |-> busy); // R7

    AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R9

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_CMD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (cmd_q == $past(cmd_q))); // R2
endmodule

bind twi_eeprom_master twi_eeprom_master_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .scl_o(scl_o), .sda_o(sda_o), .cmd_q(cmd_q)
);

// File: tb/twi_eeprom_master_test.sv
module twi_eeprom_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int S_START = 32'h100;
    localparam int S_STOP  = 32'h101;
    localparam int M_NACK  = 32'h201;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic [7:0] addr = 8'h00, wdata = 8'h00, clk_div = 8'h00;
    logic       slv_sda = 1'b1;
    logic       busy, done, ok, scl_o, sda_o;
    logic [7:0] rd_data;
    wire        sda_line = sda_o & slv_sda;

    twi_eeprom_master uut (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .addr(addr),
        .wdata(wdata), .clk_div(clk_div), .busy(busy), .done(done), .ok(ok),
        .rd_data(rd_data), .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int compared = 0, mismatched = 0;

    task automatic check_eq(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural memory on the bus ----------------
    logic [7:0] mem [256];
    int   log_q[$];
    int   exp_q[$];
    int   bitcnt = 0, frame_idx = 0, wcount = 0, nack_at = -1;
    bit   reading = 0, pending_read = 0, expect_addr = 0;
    logic master_ack = 1'b1;
    logic [7:0] ptr = 8'h00, shreg = 8'h00;

    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

    always @(negedge sda_line) if (scl_o === 1'b1) begin
        log_q.push_back(S_START);
        bitcnt = 0; frame_idx = 0; reading = 0; pending_read = 0;
        expect_addr = 0; slv_sda = 1'b1;
    end

    always @(posedge sda_line) if (scl_o === 1'b1) begin
        log_q.push_back(S_STOP);
        bitcnt = 0; reading = 0; pending_read = 0; slv_sda = 1'b1;
    end

    always @(posedge scl_o) begin
        bitcnt++;
        if (!reading) begin
            if (bitcnt <= 8) shreg = {shreg[6:0], sda_line};
        end else if (bitcnt == 9) begin
            master_ack = sda_line;
            log_q.push_back(32'h200 | int'(sda_line));
        end
    end

    always @(negedge scl_o) begin
        if (!reading) begin
            if (bitcnt == 8) begin
                log_q.push_back(int'(shreg));
                if (wcount == nack_at) begin
                    slv_sda = 1'b1;
                end else begin
                    slv_sda = 1'b0;
                    if (frame_idx == 0) begin
                        if (shreg[0]) pending_read = 1; else expect_addr = 1;
                    end else if (expect_addr) begin
                        ptr = shreg; expect_addr = 0;
                    end else begin
                        mem[ptr] = shreg; ptr++;
                    end
                end
                frame_idx++; wcount++;
            end else if (bitcnt == 9) begin
                bitcnt = 0;
                if (pending_read) begin
                    pending_read = 0; reading = 1; slv_sda = mem[ptr][7];
                end else slv_sda = 1'b1;
            end
        end else begin
            if (bitcnt >= 1 && bitcnt <= 7) slv_sda = mem[ptr][7-bitcnt];
            else if (bitcnt == 8) slv_sda = 1'b1;
            else if (bitcnt == 9) begin
                bitcnt = 0; ptr++;
                if (master_ack == 1'b0) slv_sda = mem[ptr][7];
                else begin reading = 0; slv_sda = 1'b1; end
            end
        end
    end

    // ---------------- cycle-level model of busy/done (R9) ----------------
    int model_len = 0, exp_left = 0;
    bit exp_done = 0;

    always @(posedge clk) begin
        if (rst) begin
            exp_left <= 0; exp_done <= 0;
        end else begin
            exp_done <= (exp_left == 1);
            if (exp_left > 0) exp_left <= exp_left - 1;
            else if (start) exp_left <= model_len;
        end
    end

    always @(negedge clk) if (!rst) begin
        check_eq("R9", "busy per cycle", int'(busy), int'(exp_left > 0));
        check_eq("R9", "done per cycle", int'(done), int'(exp_done));
    end

    // ---------------- SCL timing monitor (R8) ----------------
    int cyc = 0, hi_run = 0;
    int rise_q[$], hi_q[$];
    logic scl_prev = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (scl_o && busy) hi_run++;
            else if (hi_run > 0) begin hi_q.push_back(hi_run); hi_run = 0; end
            if (scl_o && !scl_prev) rise_q.push_back(cyc);
            scl_prev = scl_o;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    task automatic run_txn(input logic [1:0] c, input logic [7:0] a, input logic [7:0] d,
                           input logic [7:0] dv, input int nack, input int slots,
                           input bit exp_ok, input logic [7:0] exp_rd,
                           input bit poke, input string req);
        nack_at = nack; wcount = 0;
        model_len = slots * 4 * (int'(dv) + 1);
        log_q.delete(); rise_q.delete(); hi_q.delete(); hi_run = 0;
        @(negedge clk);
        cmd = c; addr = a; wdata = d; clk_div = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            cmd = 2'b10; addr = 8'h99; wdata = 8'h11; clk_div = 8'h05; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        check_eq(req, "status ok", int'(ok), int'(exp_ok));
        check_eq(req, "rd_data", int'(rd_data), int'(exp_rd));
        check_eq("R7", "bus event count", log_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
            check_eq(req, "bus event", log_q[i], exp_q[i]);
        repeat (5) @(negedge clk);
        check_eq("R9", "ok held after done", int'(ok), int'(exp_ok));
    endtask

    task automatic check_timing(input int d);
        check_eq("R8", "scl high cycles", (hi_q.size() > 2) ? hi_q[2] : -1, 2 * d);
        check_eq("R8", "scl bit period", (rise_q.size() > 2) ? rise_q[2] - rise_q[1] : -1, 4 * d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_eq("R1", "scl_o in reset", int'(scl_o), 1);
        check_eq("R1", "sda_o in reset", int'(sda_o), 1);
        check_eq("R1", "busy in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "done after reset", int'(done), 0);
        check_eq("R1", "ok after reset", int'(ok), 0);
        check_eq("R1", "rd_data after reset", int'(rd_data), 0);
        check_eq("R1", "lines idle", int'({scl_o, sda_o}), 3);

        // R3 byte write, 29 slots
        exp_q = '{S_START, 32'hA0, 32'h12, 32'hC3, S_STOP};
        run_txn(2'b00, 8'h12, 8'hC3, 8'd1, -1, 29, 1'b1, 8'h00, 1'b0, "R3");
        check_timing(2);

        // R5 random read back, 39 slots
        exp_q = '{S_START, 32'hA0, 32'h12, S_START, 32'hA1, M_NACK, S_STOP};
        run_txn(2'b10, 8'h12, 8'h00, 8'd0, -1, 39, 1'b1, 8'hC3, 1'b0, "R5");

        // R4 current read from advanced pointer 0x13
        exp_q = '{S_START, 32'hA1, M_NACK, S_STOP};
        run_txn(2'b01, 8'hEE, 8'h00, 8'd2, -1, 20, 1'b1, 8'h13 ^ 8'h5A, 1'b0, "R4");

        // R6 memory busy: control byte not acknowledged, 11 slots
        exp_q = '{S_START, 32'hA0, S_STOP};
        run_txn(2'b00, 8'h05, 8'h66, 8'd1, 0, 11, 1'b0, 8'h13 ^ 8'h5A, 1'b0, "R6");

        // R6 random read aborted at address, 20 slots
        exp_q = '{S_START, 32'hA0, 32'h40, S_STOP};
        run_txn(2'b10, 8'h40, 8'h00, 8'd0, 1, 20, 1'b0, 8'h13 ^ 8'h5A, 1'b0, "R6");

        // R2 start while busy ignored (write 0x20 <- 0x7E)
        exp_q = '{S_START, 32'hA0, 32'h20, 32'h7E, S_STOP};
        run_txn(2'b00, 8'h20, 8'h7E, 8'd1, -1, 29, 1'b1, 8'h13 ^ 8'h5A, 1'b1, "R2");

        // R4 code 11 acts as current read, pointer now 0x21
        exp_q = '{S_START, 32'hA1, M_NACK, S_STOP};
        run_txn(2'b11, 8'h00, 8'h00, 8'd0, -1, 20, 1'b1, 8'h21 ^ 8'h5A, 1'b0, "R4");

        // R6 data byte not acknowledged, full 29 slots
        exp_q = '{S_START, 32'hA0, 32'h30, 32'h55, S_STOP};
        run_txn(2'b00, 8'h30, 8'h55, 8'd1, 2, 29, 1'b0, 8'h21 ^ 8'h5A, 1'b0, "R6");

        // R5 random read of 0x20 with slow divider, R8 timing
        exp_q = '{S_START, 32'hA0, 32'h20, S_START, 32'hA1, M_NACK, S_STOP};
        run_txn(2'b10, 8'h20, 8'h00, 8'd3, -1, 39, 1'b1, 8'h7E, 1'b0, "R5");
        check_timing(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule